// File: doc/BRIEF.md
# Class-of-Service Memory Command Arbiter

This block picks one command per cycle from a queue of slots, each slot holding a pending memory command from some requesting master. Every command carries a connection ID. One connection ID can be placed in a high service class through a configuration register. That register also holds a class enable bit and a 4-bit wait limit. High-class commands go ahead of all other traffic. Each slot keeps its own age counter. When a high-class command has waited longer than the wait limit, it is forced out ahead of the normal round-robin order among high-class commands. The downstream command bus signals through `issue_ok` whether it can take a command this cycle. Only then is a grant given.

A slot raises `slot_req` with its connection ID on `slot_cid`. It holds both steady until `slot_gnt` for that slot is high in a cycle. It may then drop the request, or present a new command at once, which starts a fresh wait. The grant is combinational: it is valid in the same cycle as the request state that produced it.

Arbitration is run by a three-state machine:
- ST_PLAIN: class mapping is off, and commands are taken oldest first.
- ST_CLASS: mapping is on, and no high-class command is past its limit.
- ST_FORCE: mapping is on, and at least one high-class command is past its limit.

The transitions are:
- enable: ST_PLAIN to ST_CLASS or ST_FORCE.
- expire: ST_CLASS to ST_FORCE.
- drain: ST_FORCE to ST_CLASS.
- disable: ST_CLASS or ST_FORCE to ST_PLAIN.

The next state is computed from the ages and the configuration that take effect at the coming edge. ST_FORCE is therefore entered in the first cycle in which a command is expired.

Top module: `cos_arbiter`

## Requirements
- R1: At most one bit of `slot_gnt` is high in any cycle. It is only ever high for a slot whose `slot_req` is high, and it is a function of the current cycle's inputs and state (no added latency).
- R2: No grant is given while `issue_ok` is low. While `issue_ok` is high and any `slot_req` is high, exactly one slot is granted.
- R3: The configuration word has these fields:
  - bits [3:0]: the wait limit, reset value 0xF.
  - bit 4: the class enable, reset value 0.
  - bits [ID_W+4:5]: the mapped connection ID, reset value 0.

  A write with `cfg_we` high is applied at the clock edge and governs arbitration from the next cycle on.
- R4: With the class enable clear, the requesting slot with the largest age is granted, and equal ages go to the lowest slot index.
- R5: With the class enable set, a command whose connection ID equals the mapped ID is high class, and every other command is low class. A high-class request is always granted ahead of any low-class one.
- R6: Among high-class requests that are not expired, the first requesting slot at or after a pointer is granted, searching upward with wrap-around. After every grant the pointer becomes the granted index plus one, modulo the slot count. Its reset value is 0.
- R7: A high-class command is expired when its age is greater than the wait limit; with the limit at 0xF it is expired once it has waited 16 cycles. An expired command is granted ahead of the round-robin choice.
- R8: When several high-class commands are expired, the one with the largest age is granted, and equal ages go to the lowest slot index.
- R9: A slot's age is the number of cycles its current command has waited. It is 0 in the first cycle of a request, and it grows by one for each cycle the slot requests without a grant. It returns to 0 after a grant or when the request is dropped.
- R10: An age saturates at 2^AGE_W-1 (31 by default) rather than wrapping.
- R11: With the class enable set and no high-class request present, low-class requests are granted oldest first, and equal ages go to the lowest index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | ID_W+5 | Configuration word (limit, enable, mapped ID) |
| issue_ok | input | 1 | Command bus can accept a command this cycle |
| slot_req | input | N_SLOTS | Per-slot command pending |
| slot_cid | input | N_SLOTS*ID_W | Per-slot connection ID, slot i at bits [i*ID_W +: ID_W] |
| slot_gnt | output | N_SLOTS | Per-slot one-hot grant |

## Verification
The checker takes for granted that a slot keeps `slot_req` high and `slot_cid` unchanged from the cycle it raises a request until the cycle it sees its grant. The state machine's look-ahead into ST_FORCE depends on exactly that, and so do the checker's own age counters. The bench drives every slot through a small requester model that changes a slot only in the cycle after its grant or while it is idle, so the directed cases and the swept traffic keep within this rule. The sweep covers every wait limit with the class enable both off and on.

// File: rtl/cosarb_pkg.sv
package cosarb_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    // Arbitration mode held in the state register
    typedef enum logic [1:0] {
        ST_PLAIN = 2'd0,   // class mapping off: oldest first
        ST_CLASS = 2'd1,   // mapped class first, round-robin inside it
        ST_FORCE = 2'd2    // an expired mapped command is pending
    } arb_state_e;

    localparam int LIM_W = 4;
endpackage

// File: rtl/cosarb_cfg.sv
module cosarb_cfg #(
    parameter int ID_W  = 6,
    parameter int LIM_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [LIM_W+ID_W:0]    wdata,
    output logic [LIM_W-1:0]       lim_q,
    output logic                   map_q,
    output logic [ID_W-1:0]        id_q,
    output logic [LIM_W-1:0]       lim_nx,
    output logic                   map_nx,
    output logic [ID_W-1:0]        id_nx
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam logic [LIM_W-1:0] LIM_RST = '1;

    // values that govern arbitration from the next cycle on
    always_comb begin
        lim_nx = we ? wdata[LIM_W-1:0]          : lim_q;
        map_nx = we ? wdata[LIM_W]              : map_q;
        id_nx  = we ? wdata[LIM_W+ID_W:LIM_W+1] : id_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lim_q <= LIM_RST;
            map_q <= 1'b0;
            id_q  <= '0;
        end else begin
            lim_q <= lim_nx;
            map_q <= map_nx;
            id_q  <= id_nx;
        end
    end
endmodule

// File: rtl/cosarb_age.sv
module cosarb_age #(
    parameter int AGE_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             gnt,
    output logic [AGE_W-1:0] age_q,
    output logic [AGE_W-1:0] age_nx
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam logic [AGE_W-1:0] AGE_MAX = '1;

    always_comb begin
        if (req && !gnt)
            age_nx = (age_q == AGE_MAX) ? age_q : age_q + AGE_W'(1);
        else
            age_nx = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) age_q <= '0;
        else        age_q <= age_nx;
    end
endmodule

// File: rtl/cosarb_oldest.sv
module cosarb_oldest #(
    parameter int N     = 8,
    parameter int AGE_W = 5
) (
    input  logic [N-1:0]       cand,
    input  logic [N*AGE_W-1:0] ages,
    output logic [N-1:0]       sel,
    output logic               any
);
    timeunit 1ns;
    timeprecision 100ps;

    logic [AGE_W-1:0] best;

    // strict compare: equal ages keep the lower index
    always_comb begin
        sel  = '0;
        any  = 1'b0;
        best = '0;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (!any || ages[i*AGE_W +: AGE_W] > best)) begin
                sel      = '0;
                sel[i]   = 1'b1;
                best     = ages[i*AGE_W +: AGE_W];
                any      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/cosarb_rr.sv
module cosarb_rr #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     cand,
    input  logic [IDX_W-1:0] ptr,
    output logic [N-1:0]     sel
);
    timeunit 1ns;
    timeprecision 100ps;

    logic             found;
    logic [IDX_W-1:0] idx;

    // N is a power of two, so the index wraps by width
    always_comb begin
        sel   = '0;
        found = 1'b0;
        idx   = '0;
        for (int k = 0; k < N; k++) begin
            idx = ptr + IDX_W'(k);
            if (!found && cand[idx]) begin
                sel[idx] = 1'b1;
                found    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/cos_arbiter.sv
module cos_arbiter #(
    parameter int N_SLOTS = 8,   // power of two
    parameter int ID_W    = 6,
    parameter int AGE_W   = 5,   // must exceed the limit width
    parameter int LIM_W   = cosarb_pkg::LIM_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [LIM_W+ID_W:0]     cfg_wdata,
    input  logic                    issue_ok,
    input  logic [N_SLOTS-1:0]      slot_req,
    input  logic [N_SLOTS*ID_W-1:0] slot_cid,
    output logic [N_SLOTS-1:0]      slot_gnt
);
    timeunit 1ns;
    timeprecision 100ps;
    import cosarb_pkg::*;

    localparam int IDX_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1;

    arb_state_e state_q, state_d;

    logic [LIM_W-1:0] lim_q, lim_nx;
    logic             map_q, map_nx;
    logic [ID_W-1:0]  id_q, id_nx;

    logic [N_SLOTS*AGE_W-1:0] age_flat;
    logic [N_SLOTS*AGE_W-1:0] age_nx_flat;
    logic [N_SLOTS-1:0]       high_req, low_req, exp_now, exp_nx;
    logic [N_SLOTS-1:0]       sel_all, sel_low, sel_exp, sel_rr, pick;
    logic                     any_all, any_low, any_exp;
    logic [IDX_W-1:0]         ptr_q, gnt_idx;

    cosarb_cfg #(.ID_W(ID_W), .LIM_W(LIM_W)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .wdata  (cfg_wdata),
        .lim_q  (lim_q),
        .map_q  (map_q),
        .id_q   (id_q),
        .lim_nx (lim_nx),
        .map_nx (map_nx),
        .id_nx  (id_nx)
    );

    // per-slot age counter and class decode
    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        logic [ID_W-1:0]  cid;
        logic [AGE_W-1:0] age_q, age_nx;

        assign cid = slot_cid[g*ID_W +: ID_W];

        cosarb_age #(.AGE_W(AGE_W)) u_age (
            .clk    (clk),
            .rst_n  (rst_n),
            .req    (slot_req[g]),
            .gnt    (slot_gnt[g]),
            .age_q  (age_q),
            .age_nx (age_nx)
        );

        assign age_flat[g*AGE_W +: AGE_W]    = age_q;
        assign age_nx_flat[g*AGE_W +: AGE_W] = age_nx;
        assign high_req[g] = slot_req[g] && map_q && (cid == id_q);
        assign low_req[g]  = slot_req[g] && !high_req[g];
        assign exp_now[g]  = high_req[g] && (age_q > AGE_W'(lim_q));
        // look-ahead: a held, ungranted mapped command past the next limit
        assign exp_nx[g]   = map_nx && slot_req[g] && !slot_gnt[g] &&
                             (cid == id_nx) && (age_nx > AGE_W'(lim_nx));
    end

    cosarb_oldest #(.N(N_SLOTS), .AGE_W(AGE_W)) u_old_all (
        .cand (slot_req), .ages (age_flat), .sel (sel_all), .any (any_all)
    );
    cosarb_oldest #(.N(N_SLOTS), .AGE_W(AGE_W)) u_old_low (
        .cand (low_req), .ages (age_flat), .sel (sel_low), .any (any_low)
    );
    cosarb_oldest #(.N(N_SLOTS), .AGE_W(AGE_W)) u_old_exp (
        .cand (exp_now), .ages (age_flat), .sel (sel_exp), .any (any_exp)
    );
    cosarb_rr #(.N(N_SLOTS), .IDX_W(IDX_W)) u_rr (
        .cand (high_req), .ptr (ptr_q), .sel (sel_rr)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PLAIN;
        else        state_q <= state_d;
    end

    // transitions: enable, expire, drain, disable
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PLAIN: begin
                if (map_nx) state_d = (|exp_nx) ? ST_FORCE : ST_CLASS;
            end
            ST_CLASS: begin
                if (!map_nx)      state_d = ST_PLAIN;
                else if (|exp_nx) state_d = ST_FORCE;
            end
            ST_FORCE: begin
                if (!map_nx)       state_d = ST_PLAIN;
                else if (!(|exp_nx)) state_d = ST_CLASS;
            end
            default: state_d = ST_PLAIN;
        endcase
    end

    // grant selection per state
    always_comb begin
        pick = '0;
        unique case (state_q)
            ST_PLAIN: pick = sel_all;
            ST_CLASS: pick = (|high_req) ? sel_rr : sel_low;
            ST_FORCE: begin
                if (any_exp)        pick = sel_exp;
                else if (|high_req) pick = sel_rr;
                else                pick = sel_low;
            end
            default: pick = '0;
        endcase
        slot_gnt = (issue_ok && any_all) ? pick : '0;
    end

    always_comb begin
        gnt_idx = '0;
        for (int i = 0; i < N_SLOTS; i++)
            if (slot_gnt[i]) gnt_idx = IDX_W'(i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         ptr_q <= '0;
        else if (|slot_gnt) ptr_q <= gnt_idx + IDX_W'(1);
    end

    logic unused_ok;
    assign unused_ok = any_low;
endmodule

// File: rtl/cos_arbiter_chk.sv
module cos_arbiter_chk #(
    parameter int N_SLOTS = 8,
    parameter int ID_W    = 6,
    parameter int AGE_W   = 5,
    parameter int LIM_W   = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cfg_we,
    input logic [LIM_W+ID_W:0]     cfg_wdata,
    input logic                    issue_ok,
    input logic [N_SLOTS-1:0]      slot_req,
    input logic [N_SLOTS*ID_W-1:0] slot_cid,
    input logic [N_SLOTS-1:0]      slot_gnt,
    input cosarb_pkg::arb_state_e  state
);
    timeunit 1ns;
    timeprecision 100ps;
    import cosarb_pkg::*;

    logic [LIM_W-1:0] c_lim;
    logic             c_map;
    logic [ID_W-1:0]  c_id;
    logic [N_SLOTS-1:0] c_hi, c_exp;
    logic [AGE_W-1:0]   c_age [N_SLOTS];
    logic [AGE_W-1:0]   c_max_exp, c_gnt_age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_lim <= '1;
            c_map <= 1'b0;
            c_id  <= '0;
        end else if (cfg_we) begin
            c_lim <= cfg_wdata[LIM_W-1:0];
            c_map <= cfg_wdata[LIM_W];
            c_id  <= cfg_wdata[LIM_W+ID_W:LIM_W+1];
        end
    end

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_c
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) c_age[g] <= '0;
            else if (slot_req[g] && !slot_gnt[g])
                c_age[g] <= (&c_age[g]) ? c_age[g] : c_age[g] + AGE_W'(1);
            else c_age[g] <= '0;
        end
        assign c_hi[g]  = c_map && slot_req[g] &&
                          (slot_cid[g*ID_W +: ID_W] == c_id);
        assign c_exp[g] = c_hi[g] && (c_age[g] > AGE_W'(c_lim));
    end

    always_comb begin
        c_max_exp = '0;
        c_gnt_age = '0;
        for (int i = 0; i < N_SLOTS; i++) begin
            if (c_exp[i] && c_age[i] > c_max_exp) c_max_exp = c_age[i];
            if (slot_gnt[i]) c_gnt_age = c_age[i];
        end
    end

    p_one_hot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_gnt));
    p_gnt_has_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_gnt & ~slot_req) == '0);
    p_no_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_ok |-> slot_gnt == '0);
    p_work_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_ok && |slot_req) |-> |slot_gnt);
    p_plain_state_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PLAIN) == !c_map);
    p_high_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_ok && |c_hi) |-> |(slot_gnt & c_hi));
    p_expired_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_ok && |c_exp) |-> |(slot_gnt & c_exp));
    p_force_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FORCE) == (|c_exp));
    p_oldest_exp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_ok && |c_exp) |-> c_gnt_age == c_max_exp);
endmodule

bind cos_arbiter cos_arbiter_chk #(
    .N_SLOTS (N_SLOTS),
    .ID_W    (ID_W),
    .AGE_W   (AGE_W),
    .LIM_W   (LIM_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .issue_ok  (issue_ok),
    .slot_req  (slot_req),
    .slot_cid  (slot_cid),
    .slot_gnt  (slot_gnt),
    .state     (state_q)
);

// File: tb/cos_arbiter_tb_top.sv
module cos_arbiter_tb_top;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int N    = 8;
    localparam int IDW  = 6;
    localparam int AGEW = 5;
    localparam int LIMW = 4;
    localparam int CFGW = LIMW + 1 + IDW;
    localparam int AMAX = (1 << AGEW) - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_we = 1'b0;
    logic [CFGW-1:0] cfg_wdata = '0;
    logic            issue_ok = 1'b0;
    logic [N-1:0]    slot_req = '0;
    logic [N*IDW-1:0] slot_cid;
    logic [N-1:0]    slot_gnt;
    logic [IDW-1:0]  cid_a [N];

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    int m_age [N];
    int m_ptr, m_lim, m_map, m_id;
    logic [N-1:0] last_got;

    always #2.5 clk = ~clk;

    always_comb
        for (int i = 0; i < N; i++) slot_cid[i*IDW +: IDW] = cid_a[i];

    cos_arbiter #(.N_SLOTS(N), .ID_W(IDW), .AGE_W(AGEW), .LIM_W(LIMW)) dut_i (
        .clk (clk), .rst_n (rst_n), .cfg_we (cfg_we), .cfg_wdata (cfg_wdata),
        .issue_ok (issue_ok), .slot_req (slot_req), .slot_cid (slot_cid),
        .slot_gnt (slot_gnt)
    );

    function automatic int oldest_of(logic [N-1:0] c);
        int best = -1;
        int ba = -1;
        for (int i = 0; i < N; i++)
            if (c[i] && m_age[i] > ba) begin ba = m_age[i]; best = i; end
        return best;
    endfunction

    function automatic int model_pick();
        logic [N-1:0] hi, lo, ex;
        if (!issue_ok || slot_req == '0) return -1;
        if (m_map == 0) return oldest_of(slot_req);
        for (int i = 0; i < N; i++) begin
            hi[i] = slot_req[i] && (int'(cid_a[i]) == m_id);
            ex[i] = hi[i] && (m_age[i] > m_lim);
            lo[i] = slot_req[i] && !hi[i];
        end
        if (ex != '0) return oldest_of(ex);
        if (hi != '0)
            for (int k = 0; k < N; k++)
                if (hi[(m_ptr + k) % N]) return (m_ptr + k) % N;
        return oldest_of(lo);
    endfunction

    function automatic int enc(logic [N-1:0] g);
        if ($countones(g) > 1) return -3;
        for (int i = 0; i < N; i++) if (g[i]) return i;
        return -1;
    endfunction

    task automatic check(input string tag, input int act, input int expv);
        n_tests++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: granted slot %0d, expected slot %0d", tag, act, expv);
        end
    endtask

    // one cycle: inputs already driven at this negedge
    task automatic cyc(input string tag, input int want);
        logic [N-1:0]    g, rq;
        logic            we;
        logic [CFGW-1:0] wd;
        int d;
        #1;
        g = slot_gnt;
        d = enc(g);
        check(tag, d, model_pick());
        if (want != -2) check({tag, " (fixed)"}, d, want);
        rq = slot_req; we = cfg_we; wd = cfg_wdata;
        @(posedge clk);
        for (int i = 0; i < N; i++)
            if (rq[i] && !g[i]) m_age[i] = (m_age[i] >= AMAX) ? AMAX : m_age[i] + 1;
            else m_age[i] = 0;
        if (d >= 0) m_ptr = (d + 1) % N;
        if (we) begin
            m_lim = int'(wd[LIMW-1:0]);
            m_map = int'(wd[LIMW]);
            m_id  = int'(wd[CFGW-1:LIMW+1]);
        end
        last_got = g;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; slot_req = '0; issue_ok = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
        for (int i = 0; i < N; i++) begin cid_a[i] = '0; m_age[i] = 0; end
        m_ptr = 0; m_lim = 15; m_map = 0; m_id = 0; last_got = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic write_cfg(input int lim, input int map, input int id, input string tag);
        cfg_wdata = {IDW'(id), 1'(map), LIMW'(lim)};
        cfg_we = 1'b1;
        cyc(tag, -2);
        cfg_we = 1'b0;
    endtask

    task automatic raise(input int s, input int id);
        slot_req[s] = 1'b1;
        cid_a[s] = IDW'(id);
    endtask

    function automatic logic [IDW-1:0] pick_cid(input int hid);
        int r = int'($urandom % 4);
        if (r < 2) return IDW'(hid);
        if (r == 2) return IDW'(hid ^ 1);
        return IDW'($urandom % 64);
    endfunction

    task automatic traffic(input int ncyc, input int pct, input int hid);
        for (int c = 0; c < ncyc; c++) begin
            for (int i = 0; i < N; i++) begin
                if (last_got[i]) begin
                    if (($urandom % 2) == 1) slot_req[i] = 1'b0;
                    else cid_a[i] = pick_cid(hid);
                end
                if (!slot_req[i] && ($urandom % 3) == 0) begin
                    slot_req[i] = 1'b1;
                    cid_a[i] = pick_cid(hid);
                end
            end
            issue_ok = int'($urandom % 100) < pct;
            cyc("R1 R2 R4 R5 R6 R7 R8 R9 R10 R11 traffic", -2);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: run did not finish, got hang, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        @(negedge clk);
        // R3: reset state, nothing granted, mapping off
        do_reset();
        issue_ok = 1'b1;
        cyc("R3 reset: no request, no grant", -1);
        issue_ok = 1'b0;
        raise(1, 9);
        cyc("R2 issue_ok low", -1);
        cyc("R2 issue_ok low", -1);
        raise(3, 0);
        cfg_wdata = {IDW'(0), 1'b1, LIMW'(15)};
        cfg_we = 1'b1;
        issue_ok = 1'b1;
        cyc("R3 write not in effect this cycle, plain oldest", 1);
        cfg_we = 1'b0;
        cid_a[1] = IDW'(9);
        cyc("R3 write in effect next cycle, mapped ID 0 first", 3);

        // R7: limit 15, age 15 is not expired
        do_reset();
        write_cfg(15, 1, 'h25, "R3 cfg write");
        raise(5, 'h25);
        for (int k = 0; k < 15; k++) begin
            if (k == 10) raise(1, 'h25);
            cyc("R2 hold", -1);
        end
        issue_ok = 1'b1;
        cyc("R7 age 15 with limit 15 uses round-robin", 1);

        // R7: limit 15, age 16 is expired
        do_reset();
        write_cfg(15, 1, 'h25, "R3 cfg write");
        raise(5, 'h25);
        for (int k = 0; k < 16; k++) begin
            if (k == 10) raise(1, 'h25);
            cyc("R2 hold", -1);
        end
        issue_ok = 1'b1;
        cyc("R7 age 16 with limit 15 forced", 5);

        // R7: limit 0, one cycle of waiting expires
        do_reset();
        write_cfg(0, 1, 'h25, "R3 cfg write");
        raise(5, 'h25);
        cyc("R2 hold", -1);
        raise(1, 'h25);
        issue_ok = 1'b1;
        cyc("R7 limit 0 forces age 1", 5);

        // R8: two expired, oldest first, then expired over round-robin
        do_reset();
        write_cfg(2, 1, 'h25, "R3 cfg write");
        raise(6, 'h25);
        cyc("R2 hold", -1);
        cyc("R2 hold", -1);
        raise(3, 'h25);
        for (int k = 0; k < 4; k++) cyc("R2 hold", -1);
        raise(0, 'h25);
        issue_ok = 1'b1;
        cyc("R8 oldest expired first", 6);
        slot_req[6] = 1'b0;
        cyc("R8 expired beats round-robin pointer", 3);

        // R6: round-robin among mapped commands
        do_reset();
        write_cfg(15, 1, 'h25, "R3 cfg write");
        raise(2, 'h25); raise(5, 'h25); raise(6, 'h25);
        issue_ok = 1'b1;
        cyc("R6 pointer 0 picks slot 2", 2);
        cyc("R6 pointer 3 picks slot 5", 5);
        cyc("R6 pointer 6 picks slot 6", 6);
        cyc("R6 pointer wraps to slot 2", 2);

        // R5 and R11: mapped first, then low class oldest first
        do_reset();
        write_cfg(15, 1, 'h25, "R3 cfg write");
        raise(0, 'h11);
        cyc("R2 hold", -1);
        cyc("R2 hold", -1);
        raise(2, 'h24);
        cyc("R2 hold", -1);
        cyc("R2 hold", -1);
        raise(7, 'h25);
        issue_ok = 1'b1;
        cyc("R5 mapped ID wins over older low class", 7);
        slot_req[7] = 1'b0;
        cyc("R11 oldest low class", 0);
        slot_req[0] = 1'b0;
        cyc("R11 remaining low class", 2);

        // R4 and R9: oldest first, age cleared on grant
        do_reset();
        raise(3, 7);
        cyc("R2 hold", -1);
        raise(4, 7);
        issue_ok = 1'b1;
        cyc("R4 oldest first with mapping off", 3);
        cid_a[3] = IDW'(8);
        cyc("R9 age cleared after grant", 4);

        // R10: ages saturate, so the tie goes to the lower index
        do_reset();
        raise(6, 9);
        for (int k = 0; k < 3; k++) cyc("R2 hold", -1);
        raise(2, 9);
        for (int k = 0; k < 40; k++) cyc("R2 hold", -1);
        issue_ok = 1'b1;
        cyc("R10 saturated ages tie to lowest index", 2);

        // sweep every wait limit with mapping off and on
        for (int mp = 0; mp < 2; mp++) begin
            for (int lim = 0; lim < 16; lim++) begin
                int hid;
                hid = (lim * 5 + 'h25) % 64;
                write_cfg(lim, mp, hid, "R3 sweep cfg write");
                traffic(250, 30 + 5 * (lim % 4), hid);
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule